// File: doc/BRIEF.md
# Key-On Envelope Rate Scaler

The block adds a keyboard-tracking offset to envelope stage rates. When a note starts on an operator slot, the host presents a key-on strobe carrying the slot number, the voice pitch and a 3-bit scaling depth. The block turns the upper pitch bits into a key index and reads a rounded key-times-depth-over-seven term from a table. The table is built when the design is elaborated, so no divider is present at run time. The term is then held in a register belonging to that slot for the rest of the note.

Envelope logic queries the block with a slot number and a base stage rate. One clock later the block returns the base rate plus that slot's held term, saturated to the 6-bit rate range. Pitch movement after key-on, such as modulation or glides, has no effect on the term until the next key-on for the slot.

Top module: `env_rate_scaler`

## Requirements
- R1: The key index is `kon_pitch_i[13:8]` minus 16, limited to the range 0 to 27 (a value below 16 gives 0, a value above 43 gives 27).
- R2: The scaling term is the key index times the depth, divided by 7 and rounded to nearest with halves rounded up, that is floor((2*key*depth + 7) / 14), giving 0 to 27.
- R3: A query with `qry_valid_i` high returns, on the next clock, `rate_valid_o` high and `rate_o` equal to min(`qry_base_i` + held term of `qry_slot_i`, 63). Without a query, `rate_valid_o` is low on the next clock.
- R4: A slot's term changes only on a key-on to that slot. Changes to the pitch or depth inputs without a key-on strobe leave every held term unchanged.
- R5: A depth of 0 gives a term of 0, so the returned rate equals the base rate.
- R6: After reset every held term is 0 and `rate_valid_o` is low.
- R7: When a key-on and a query name the same slot in the same cycle, the query result uses the new term.
- R8: A key-on to one slot leaves the terms of all other slots unchanged. Slot numbers at or above 96 are ignored on key-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| kon_valid_i | input | 1 | Key-on strobe for one cycle |
| kon_slot_i | input | 7 | Slot (voice times operators plus operator) receiving the key-on |
| kon_pitch_i | input | 14 | Voice pitch at key-on |
| kon_depth_i | input | 3 | Rate-scaling depth, 0 to 7 |
| qry_valid_i | input | 1 | Rate query strobe |
| qry_slot_i | input | 7 | Slot whose held term is applied |
| qry_base_i | input | 6 | Base envelope stage rate |
| rate_valid_o | output | 1 | Result valid, one cycle after the query |
| rate_o | output | 6 | Scaled and saturated rate |

## Verification
A corrupted held term appears as a wrong `rate_o` on the first query to that slot, one clock after the query. It stays hidden until that slot is queried, so the stimulus queries every slot many times between key-ons. A wrong table entry or key clamp appears only for the pitch and depth pair that selects it. Directed cases therefore cover the clamp edges at index 0 and 27, the rounding points of the divide by seven, and saturation at 63. Random key-ons with full-range pitch fill in the remaining table entries.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Rounded key*depth/dmax, computed with integers only: floor((2kd+dmax)/(2dmax))
  function automatic int rs_scaled_term(input int key, input int depth, input int dmax);
    return (2 * key * depth + dmax) / (2 * dmax);
  endfunction

endpackage

// File: rtl/rs_key_index.sv
module rs_key_index #(
  parameter int PITCH_W    = 14,
  parameter int KEY_SHIFT  = 8,
  parameter int KEY_OFFSET = 16,
  parameter int KEY_MAX    = 27,
  parameter int KEY_W      = 5
) (
  input  logic [PITCH_W-1:0] pitch_i,
  output logic [KEY_W-1:0]   key_o
);
  localparam int HI_W = PITCH_W - KEY_SHIFT;

  logic [HI_W-1:0] hi;
  int              diff;

  assign hi   = pitch_i[PITCH_W-1:KEY_SHIFT];
  assign diff = int'(hi) - KEY_OFFSET;

  always_comb begin
    if (diff < 0)            key_o = '0;
    else if (diff > KEY_MAX) key_o = KEY_W'(KEY_MAX);
    else                     key_o = KEY_W'(diff);
  end

  // R1: index never leaves the clamp window
  always_comb begin
    p_key_in_range_r1: assert (int'(key_o) <= KEY_MAX);
  end
endmodule

// File: rtl/rs_term_rom.sv
module rs_term_rom
  import rs_pkg::*;
#(
  parameter int KEY_W    = 5,
  parameter int KEY_SPAN = 28,
  parameter int DEPTH_W  = 3,
  parameter int TERM_W   = 5
) (
  input  logic [KEY_W-1:0]   key_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [TERM_W-1:0]  term_o
);
  localparam int DEPTHS  = 1 << DEPTH_W;
  localparam int DMAX    = DEPTHS - 1;
  localparam int KEYS    = 1 << KEY_W;
  localparam int ENTRIES = KEYS * DEPTHS;

  logic [TERM_W-1:0] rom [ENTRIES];

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    for (genvar d = 0; d < DEPTHS; d++) begin : g_depth
      localparam int KEFF = (k < KEY_SPAN) ? k : KEY_SPAN - 1;
      assign rom[k * DEPTHS + d] = TERM_W'(rs_scaled_term(KEFF, d, DMAX));
    end
  end

  assign term_o = rom[{key_i, depth_i}];

  // R2: depth/dmax <= 1 so the term can never exceed the key index
  always_comb begin
    p_term_le_key_r2: assert (int'(term_o) <= int'(key_i));
  end
endmodule

// File: rtl/rs_term_store.sv
module rs_term_store #(
  parameter int NUM_SLOTS = 96,
  parameter int SLOT_W    = 7,
  parameter int TERM_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [TERM_W-1:0] wr_term_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [TERM_W-1:0] rd_term_o
);
  logic [TERM_W-1:0] term_q [NUM_SLOTS];
  logic [TERM_W-1:0] term_d [NUM_SLOTS];
  logic              wr_ok;

  assign wr_ok = wr_en_i && (int'(wr_slot_i) < NUM_SLOTS);

  always_comb begin
    term_d = term_q;
    if (wr_ok) term_d[wr_slot_i] = wr_term_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) term_q[s] <= '0;
    end else if (wr_ok) begin
      term_q <= term_d;
    end
  end

  // R7: same-slot write bypasses the register
  always_comb begin
    if (wr_ok && (wr_slot_i == rd_slot_i))   rd_term_o = wr_term_i;
    else if (int'(rd_slot_i) < NUM_SLOTS)    rd_term_o = term_q[rd_slot_i];
    else                                     rd_term_o = '0;
  end

  // R4, R8: a slot holds its term unless it is the key-on target
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hold
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && (wr_slot_i == SLOT_W'(s))) |=> $stable(term_q[s]));
  end
endmodule

// File: rtl/env_rate_scaler.sv
module env_rate_scaler #(
  parameter int NUM_VOICES = 16,
  parameter int NUM_OPS    = 6,
  parameter int PITCH_W    = 14,
  parameter int KEY_SHIFT  = 8,
  parameter int KEY_OFFSET = 16,
  parameter int KEY_SPAN   = 28,
  parameter int DEPTH_W    = 3,
  parameter int RATE_W     = 6,
  localparam int NUM_SLOTS = NUM_VOICES * NUM_OPS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kon_valid_i,
  input  logic [SLOT_W-1:0]  kon_slot_i,
  input  logic [PITCH_W-1:0] kon_pitch_i,
  input  logic [DEPTH_W-1:0] kon_depth_i,
  input  logic               qry_valid_i,
  input  logic [SLOT_W-1:0]  qry_slot_i,
  input  logic [RATE_W-1:0]  qry_base_i,
  output logic               rate_valid_o,
  output logic [RATE_W-1:0]  rate_o
);
  localparam int KEY_MAX  = KEY_SPAN - 1;
  localparam int KEY_W    = $clog2(KEY_SPAN);
  localparam int TERM_W   = KEY_W;
  localparam int RATE_MAX = (1 << RATE_W) - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [KEY_W-1:0]  key;
  logic [TERM_W-1:0] new_term;
  logic [TERM_W-1:0] held_term;

  rs_key_index #(
    .PITCH_W(PITCH_W), .KEY_SHIFT(KEY_SHIFT), .KEY_OFFSET(KEY_OFFSET),
    .KEY_MAX(KEY_MAX), .KEY_W(KEY_W)
  ) u_key (
    .pitch_i(kon_pitch_i),
    .key_o  (key)
  );

  rs_term_rom #(
    .KEY_W(KEY_W), .KEY_SPAN(KEY_SPAN), .DEPTH_W(DEPTH_W), .TERM_W(TERM_W)
  ) u_rom (
    .key_i  (key),
    .depth_i(kon_depth_i),
    .term_o (new_term)
  );

  rs_term_store #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TERM_W(TERM_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en_i  (kon_valid_i),
    .wr_slot_i(kon_slot_i),
    .wr_term_i(new_term),
    .rd_slot_i(qry_slot_i),
    .rd_term_o(held_term)
  );

  // saturating add, next-state
  logic [RATE_W:0]   sum;
  logic [RATE_W-1:0] rate_d;
  logic              rate_q;
  logic [RATE_W-1:0] rate_val_q;

  assign sum    = {1'b0, qry_base_i} + (RATE_W + 1)'(held_term);
  assign rate_d = (int'(sum) > RATE_MAX) ? RATE_W'(RATE_MAX) : sum[RATE_W-1:0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rate_q <= 1'b0;
    else            rate_q <= qry_valid_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       rate_val_q <= '0;
    else if (qry_valid_i) rate_val_q <= rate_d;
  end

  assign rate_valid_o = rate_q;
  assign rate_o       = rate_val_q;

  // R3: scaling never lowers a rate
  p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    rate_valid_o |-> (rate_o >= $past(qry_base_i)));

  // R5: zero depth on a bypassed key-on returns the base unchanged
  p_zero_depth_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (qry_valid_i && kon_valid_i && (kon_slot_i == qry_slot_i) && (kon_depth_i == '0))
    |=> (rate_o == $past(qry_base_i)));

  // R3: valid output follows only a query
  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !qry_valid_i |=> !rate_valid_o);
endmodule

// File: tb/sim_env_rate_scaler.sv
module sim_env_rate_scaler;
  localparam int SLOTS = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        kon_valid, qry_valid;
  logic [6:0]  kon_slot, qry_slot;
  logic [13:0] kon_pitch;
  logic [2:0]  kon_depth;
  logic [5:0]  qry_base;
  logic        rate_valid;
  logic [5:0]  rate;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  int model [SLOTS];

  always #2.5 clk = ~clk;

  env_rate_scaler u0 (
    .clk(clk), .rst_n(rst_n),
    .kon_valid_i(kon_valid), .kon_slot_i(kon_slot), .kon_pitch_i(kon_pitch),
    .kon_depth_i(kon_depth), .qry_valid_i(qry_valid), .qry_slot_i(qry_slot),
    .qry_base_i(qry_base), .rate_valid_o(rate_valid), .rate_o(rate)
  );

  function automatic int ref_term(input int pitch, input int depth);
    int k;
    k = (pitch >> 8) - 16;
    if (k < 0)  k = 0;
    if (k > 27) k = 27;
    return (k * depth * 2 + 7) / 14;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check just after next posedge
  task automatic step(input bit kv, input int ks, input int kp, input int kd,
                      input bit qv, input int qs, input int qb, input string tag);
    int t, e;
    @(negedge clk);
    kon_valid = kv; kon_slot = 7'(ks); kon_pitch = 14'(kp); kon_depth = 3'(kd);
    qry_valid = qv; qry_slot = 7'(qs); qry_base = 6'(qb);
    if (kv && ks < SLOTS) model[ks] = ref_term(kp, kd);
    t = (qs < SLOTS) ? model[qs] : 0;
    e = (qb + t > 63) ? 63 : qb + t;
    @(posedge clk); #1;
    check({tag, " valid"}, int'(rate_valid), int'(qv));
    if (qv) check(tag, int'(rate), e);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected <100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < SLOTS; s++) model[s] = 0;
    rst_n = 1'b0; kon_valid = 0; qry_valid = 0; kon_slot = 0; qry_slot = 0;
    kon_pitch = 0; kon_depth = 0; qry_base = 0;
    repeat (3) @(posedge clk);
    #1 check("R6 reset valid", int'(rate_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R6: terms start at zero
    step(0, 0, 0, 0, 1, 5, 10, "R6 reset term");
    step(0, 0, 0, 0, 1, 95, 63, "R6 reset term top");
    step(0, 0, 0, 0, 0, 0, 0, "R3 idle");
    // R1 clamp top, R3 saturation
    step(1, 3, 14'h3FFF, 7, 0, 0, 0, "R1 kon");
    step(0, 0, 0, 0, 1, 3, 40, "R3 saturate");
    step(0, 0, 0, 0, 1, 3, 36, "R1 top 27");
    // R1 lower clamp
    step(1, 4, 14'h0FFF, 7, 1, 4, 20, "R1 below 16");
    step(1, 4, 14'h1000, 7, 1, 4, 20, "R1 exact 16");
    // R2 rounding points
    step(1, 5, 14'h1100, 3, 1, 5, 0, "R2 1*3/7");
    step(1, 5, 14'h1200, 3, 1, 5, 0, "R2 2*3/7");
    step(1, 5, 14'h1700, 1, 1, 5, 0, "R2 7*1/7");
    step(1, 5, 14'h1B00, 7, 1, 5, 0, "R2 11*7/7");
    // R5 depth zero
    step(1, 6, 14'h3FFF, 0, 1, 6, 17, "R5 depth0");
    // R7 bypass then R4 hold against pitch change with no strobe
    step(1, 7, 14'h2A00, 5, 1, 7, 30, "R7 bypass");
    step(0, 7, 14'h0000, 0, 1, 7, 30, "R4 hold");
    // R8 neighbours untouched; out-of-range key-on ignored
    step(1, 8, 14'h3000, 6, 1, 7, 12, "R8 neighbour");
    step(1, 100, 14'h3FFF, 7, 1, 95, 1, "R8 ignore high slot");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int s1, s2;
      s1 = $urandom_range(0, 99);
      s2 = ($urandom_range(0, 3) == 0) ? s1 : $urandom_range(0, 95);
      step($urandom_range(0, 2) == 0, s1, $urandom_range(0, 16383), $urandom_range(0, 7),
           $urandom_range(0, 4) != 0, s2, $urandom_range(0, 63), "R3 random");
    end
    // sweep every slot after the random run
    for (int s = 0; s < SLOTS; s++) step(0, 0, 0, 0, 1, s, 30, "R4 sweep");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule